// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is an 8-bit arithmetic and logic engine organised around an accumulator (A) and a partner register (B). Each clock cycle in which the write enable is high, the block takes a 5-bit opcode and an 8-bit operand. It computes one operation from A, the operand, B and the carry flag. It then registers the new A, B and status flags. The available operations are loads, binary and BCD-oriented arithmetic, bitwise logic, rotates, a nibble exchange, and an 8x8 multiply and an 8/8 divide that use B as the second register.

Four status flags are kept: carry, auxiliary (nibble) carry, signed overflow and parity. Parity is not tied to any operation. It always reflects the accumulator's current contents, so a load, a rotate or a divide refreshes it as well as an addition. The block sits beside an instruction sequencer. That sequencer decodes instructions into the opcode and operand presented here. It also owns fetch, addressing and register storage.

Top module: `acc_alu`

## Requirements
- R1: After reset (rst_n low), A = 0x00, B = 0x00, and carry, auxiliary carry, overflow and parity are all 0.
- R2: When wr_en_i is low, or when the opcode is unassigned (19 to 31), A, B and all four flags keep their values.
- R3: Opcode 0 copies the operand into A; opcode 1 copies the operand into B; neither changes carry, auxiliary carry or overflow.
- R4: Opcode 2 (add) and opcode 3 (add with carry-in) set A to the low 8 bits of A + operand (+ carry for 3). Carry is the carry out of bit 7, auxiliary carry is the carry out of bit 3, and overflow is set when the two inputs share a sign bit that the result does not.
- R5: Opcode 4 sets A to A - operand - carry. Carry is set on a borrow out of bit 7, auxiliary carry on a borrow out of the low nibble, and overflow when the inputs have different sign bits and the result's sign differs from A's.
- R6: Opcode 5 increments A and opcode 6 decrements A, both modulo 256, with no change to carry, auxiliary carry or overflow.
- R7: Opcodes 7, 8 and 9 set A to A AND, OR, XOR the operand. Opcode 10 inverts every bit of A. None of them changes carry, auxiliary carry or overflow.
- R8: Opcode 11 rotates A left (bit 7 to bit 0) and opcode 13 rotates A right (bit 0 to bit 7), with no flag change. Opcode 12 rotates the 9-bit value {carry, A} left and opcode 14 rotates {A, carry} right. These two change only carry and A.
- R9: Opcode 15 exchanges bits 7:4 and 3:0 of A, with no change to carry, auxiliary carry or overflow.
- R10: Opcode 16 forms A x B. A gets the low byte of the product and B gets the high byte. Carry is cleared, and overflow is set exactly when the product exceeds 255.
- R11: Opcode 17 divides A by B (unsigned). A gets the quotient, B gets the remainder, and carry and overflow are cleared. When B is 0, overflow is set, carry is cleared, and A and B keep their values.
- R12: Opcode 18 adds 0x06 to A when the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 when the resulting high nibble exceeds 9 or the carry flag, or a carry from the first addition, is set. Any carry out of bit 7 in either step sets carry. Carry is never cleared, and auxiliary carry is unchanged.
- R13: The parity flag equals the XOR of the eight bits of A in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| operand_i | input | 8 | Second operand or load value |
| wr_en_i | input | 1 | Perform the selected operation this cycle |
| acc_o | output | 8 | Accumulator A |
| breg_o | output | 8 | Partner register B |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary (nibble) carry flag |
| ov_o | output | 1 | Overflow flag |
| par_o | output | 1 | Parity of A |

## Verification
The two corrections of the decimal adjust can both fire in the same cycle. That case is forced by loading 0x99 and adding 0x99, which leaves 0x32 with carry and auxiliary carry set; the adjust must then apply both the low and the high correction and return 0x98 with carry still set. Parity and the arithmetic flags also change in the same cycle on every add, subtract and multiply. A reference model in the bench predicts all four flags together with A and B for each vector. A scoreboard compares the whole tuple one cycle after each operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_LDA  = 5'd0,
        OP_LDB  = 5'd1,
        OP_ADD  = 5'd2,
        OP_ADDC = 5'd3,
        OP_SUBB = 5'd4,
        OP_INC  = 5'd5,
        OP_DEC  = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_XOR  = 5'd9,
        OP_CPL  = 5'd10,
        OP_RL   = 5'd11,
        OP_RLC  = 5'd12,
        OP_RR   = 5'd13,
        OP_RRC  = 5'd14,
        OP_SWAP = 5'd15,
        OP_MUL  = 5'd16,
        OP_DIV  = 5'd17,
        OP_DA   = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
        logic par;
    } alu_flags_t;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] breg;
        alu_flags_t    fl;
    } alu_state_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         ac_o,
    output logic         ov_o
);
    localparam int HW = W / 2;

    logic [HW:0] low_nib;
    logic [W:0]  full_sum;

    always_comb begin
        if (sub_i) begin
            low_nib  = {1'b0, a_i[HW-1:0]} - {1'b0, b_i[HW-1:0]} - (HW+1)'(cin_i);
            full_sum = {1'b0, a_i} - {1'b0, b_i} - (W+1)'(cin_i);
            ov_o     = (a_i[W-1] ^ b_i[W-1]) & (full_sum[W-1] ^ a_i[W-1]);
        end else begin
            low_nib  = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + (HW+1)'(cin_i);
            full_sum = {1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i);
            ov_o     = ~(a_i[W-1] ^ b_i[W-1]) & (full_sum[W-1] ^ a_i[W-1]);
        end
        res_o = full_sum[W-1:0];
        cy_o  = full_sum[W];
        ac_o  = low_nib[HW];
    end

endmodule

// File: rtl/alu_rotlog.sv
module alu_rotlog
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    localparam int HW = W / 2;

    always_comb begin
        res_o = a_i;
        cy_o  = cin_i;
        unique case (op_i)
            OP_INC:  res_o = a_i + W'(1);
            OP_DEC:  res_o = a_i - W'(1);
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_CPL:  res_o = ~a_i;
            OP_RL:   res_o = {a_i[W-2:0], a_i[W-1]};
            OP_RR:   res_o = {a_i[0], a_i[W-1:1]};
            OP_RLC: begin
                res_o = {a_i[W-2:0], cin_i};
                cy_o  = a_i[W-1];
            end
            OP_RRC: begin
                res_o = {cin_i, a_i[W-1:1]};
                cy_o  = a_i[0];
            end
            OP_SWAP: res_o = {a_i[HW-1:0], a_i[W-1:HW]};
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prod_lo_o,
    output logic [W-1:0] prod_hi_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         div_zero_o
);
    logic [2*W-1:0] product;
    logic [W:0]     part_rem [W+1];
    logic [W-1:0]   q_bits;

    assign product    = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    assign prod_lo_o  = product[W-1:0];
    assign prod_hi_o  = product[2*W-1:W];
    assign div_zero_o = (b_i == '0);

    assign part_rem[0] = '0;

    for (genvar s = 0; s < W; s++) begin : g_div_stage
        logic [W:0] trial;
        logic [W:0] diff;
        assign trial = {part_rem[s][W-1:0], a_i[W-1-s]};
        assign diff  = trial - {1'b0, b_i};
        assign q_bits[W-1-s] = ~diff[W];
        assign part_rem[s+1] = diff[W] ? trial : diff;
    end

    assign quot_o = q_bits;
    assign rem_o  = part_rem[W][W-1:0];

endmodule

// File: rtl/alu_decadj.sv
module alu_decadj #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         cy_i,
    input  logic         ac_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    localparam int HW = W / 2;
    localparam logic [HW-1:0] NIB_MAX = HW'(9);

    logic       low_fix;
    logic       high_fix;
    logic [W:0] step_lo;
    logic [W:0] step_hi;

    always_comb begin
        low_fix  = ac_i | (a_i[HW-1:0] > NIB_MAX);
        step_lo  = {1'b0, a_i} + (low_fix ? (W+1)'(6) : '0);
        high_fix = cy_i | step_lo[W] | (step_lo[W-1:HW] > NIB_MAX);
        step_hi  = {1'b0, step_lo[W-1:0]} + (high_fix ? (W+1)'(6 << HW) : '0);
        res_o    = step_hi[W-1:0];
        cy_o     = cy_i | step_lo[W] | step_hi[W];
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_i,
    input  logic [DW-1:0]  operand_i,
    input  logic           wr_en_i,
    output logic [DW-1:0]  acc_o,
    output logic [DW-1:0]  breg_o,
    output logic           cy_o,
    output logic           ac_o,
    output logic           ov_o,
    output logic           par_o
);
    alu_state_t st_d;
    alu_state_t st_q;
    alu_op_e    op_sel;

    logic [DW-1:0] as_res;
    logic          as_cy;
    logic          as_ac;
    logic          as_ov;
    logic          as_sub;
    logic          as_cin;

    logic [DW-1:0] rl_res;
    logic          rl_cy;

    logic [DW-1:0] md_plo;
    logic [DW-1:0] md_phi;
    logic [DW-1:0] md_quot;
    logic [DW-1:0] md_rem;
    logic          md_dz;

    logic [DW-1:0] da_res;
    logic          da_cy;

    assign op_sel = alu_op_e'(op_i);
    assign as_sub = (op_sel == OP_SUBB);
    assign as_cin = (op_sel != OP_ADD) & st_q.fl.cy;

    alu_addsub #(.W(DW)) u_addsub (
        .a_i   (st_q.acc),
        .b_i   (operand_i),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .res_o (as_res),
        .cy_o  (as_cy),
        .ac_o  (as_ac),
        .ov_o  (as_ov)
    );

    alu_rotlog #(.W(DW)) u_rotlog (
        .op_i  (op_sel),
        .a_i   (st_q.acc),
        .b_i   (operand_i),
        .cin_i (st_q.fl.cy),
        .res_o (rl_res),
        .cy_o  (rl_cy)
    );

    alu_muldiv #(.W(DW)) u_muldiv (
        .a_i        (st_q.acc),
        .b_i        (st_q.breg),
        .prod_lo_o  (md_plo),
        .prod_hi_o  (md_phi),
        .quot_o     (md_quot),
        .rem_o      (md_rem),
        .div_zero_o (md_dz)
    );

    alu_decadj #(.W(DW)) u_decadj (
        .a_i   (st_q.acc),
        .cy_i  (st_q.fl.cy),
        .ac_i  (st_q.fl.ac),
        .res_o (da_res),
        .cy_o  (da_cy)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (op_sel)
                OP_LDA: st_d.acc  = operand_i;
                OP_LDB: st_d.breg = operand_i;
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    st_d.acc   = as_res;
                    st_d.fl.cy = as_cy;
                    st_d.fl.ac = as_ac;
                    st_d.fl.ov = as_ov;
                end
                OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR, OP_CPL,
                OP_RL, OP_RR, OP_SWAP: st_d.acc = rl_res;
                OP_RLC, OP_RRC: begin
                    st_d.acc   = rl_res;
                    st_d.fl.cy = rl_cy;
                end
                OP_MUL: begin
                    st_d.acc   = md_plo;
                    st_d.breg  = md_phi;
                    st_d.fl.cy = 1'b0;
                    st_d.fl.ov = (md_phi != '0);
                end
                OP_DIV: begin
                    st_d.fl.cy = 1'b0;
                    st_d.fl.ov = md_dz;
                    if (!md_dz) begin
                        st_d.acc  = md_quot;
                        st_d.breg = md_rem;
                    end
                end
                OP_DA: begin
                    st_d.acc   = da_res;
                    st_d.fl.cy = da_cy;
                end
                default: st_d = st_q;
            endcase
        end
        st_d.fl.par = ^st_d.acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o  = st_q.acc;
    assign breg_o = st_q.breg;
    assign cy_o   = st_q.fl.cy;
    assign ac_o   = st_q.fl.ac;
    assign ov_o   = st_q.fl.ov;
    assign par_o  = st_q.fl.par;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] op_i,
    input logic           wr_en_i,
    input logic [DW-1:0]  acc_o,
    input logic [DW-1:0]  breg_o,
    input logic           cy_o,
    input logic           ac_o,
    input logic           ov_o,
    input logic           par_o
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(acc_o) && $stable(breg_o) && $stable(cy_o)
                     && $stable(ac_o) && $stable(ov_o));

    // R13
    parity_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_o == ^acc_o);

    // R8
    rot_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == OP_RL) |=>
            acc_o == {$past(acc_o[DW-2:0]), $past(acc_o[DW-1])});

    // R8
    rot_carry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == OP_RLC) |=>
            cy_o == $past(acc_o[DW-1]) && $stable(ac_o) && $stable(ov_o));

    // R9
    swap_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == OP_SWAP) |=>
            acc_o == {$past(acc_o[NW-1:0]), $past(acc_o[DW-1:NW])});

    // R10
    mul_carry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == OP_MUL) |=> !cy_o);

    // R11
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == OP_DIV && breg_o == '0) |=>
            ov_o && !cy_o && $stable(acc_o) && $stable(breg_o));

    // R12
    da_carry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && op_i == OP_DA && cy_o) |=> cy_o && $stable(ac_o));

endmodule

bind acc_alu acc_alu_chk u_acc_alu_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .wr_en_i (wr_en_i),
    .acc_o   (acc_o),
    .breg_o  (breg_o),
    .cy_o    (cy_o),
    .ac_o    (ac_o),
    .ov_o    (ov_o),
    .par_o   (par_o)
);

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] operand_i = '0;
    logic       wr_en_i = 1'b0;
    logic [7:0] acc_o;
    logic [7:0] breg_o;
    logic       cy_o, ac_o, ov_o, par_o;

    always #10 clk = ~clk;

    acc_alu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .operand_i (operand_i),
        .wr_en_i   (wr_en_i),
        .acc_o     (acc_o),
        .breg_o    (breg_o),
        .cy_o      (cy_o),
        .ac_o      (ac_o),
        .ov_o      (ov_o),
        .par_o     (par_o)
    );

    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        logic       cy, ac, ov, p;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    logic [7:0] m_a = 0, m_b = 0;
    logic       m_cy = 0, m_ac = 0, m_ov = 0;

    task automatic compare(input exp_t e);
        n_chk++;
        if (acc_o !== e.a || breg_o !== e.b || cy_o !== e.cy || ac_o !== e.ac
            || ov_o !== e.ov || par_o !== e.p) begin
            n_fail++;
            $display("FAIL %s: actual A=%h B=%h cy=%b ac=%b ov=%b p=%b expected A=%h B=%h cy=%b ac=%b ov=%b p=%b",
                     e.tag, acc_o, breg_o, cy_o, ac_o, ov_o, par_o,
                     e.a, e.b, e.cy, e.ac, e.ov, e.p);
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic [7:0] v,
                         input logic we, input string tag);
        logic [8:0] s;
        logic [4:0] n;
        logic [15:0] pr;
        logic        c1;
        exp_t e;
        if (we) begin
            case (op)
                5'd0: m_a = v;
                5'd1: m_b = v;
                5'd2, 5'd3: begin
                    s = {1'b0, m_a} + {1'b0, v} + ((op == 5'd3) ? {8'd0, m_cy} : 9'd0);
                    n = {1'b0, m_a[3:0]} + {1'b0, v[3:0]} + ((op == 5'd3) ? {4'd0, m_cy} : 5'd0);
                    m_ov = (m_a[7] == v[7]) && (s[7] != m_a[7]);
                    m_a = s[7:0]; m_cy = s[8]; m_ac = n[4];
                end
                5'd4: begin
                    s = {1'b0, m_a} - {1'b0, v} - {8'd0, m_cy};
                    n = {1'b0, m_a[3:0]} - {1'b0, v[3:0]} - {4'd0, m_cy};
                    m_ov = (m_a[7] != v[7]) && (s[7] != m_a[7]);
                    m_a = s[7:0]; m_cy = s[8]; m_ac = n[4];
                end
                5'd5: m_a = m_a + 8'd1;
                5'd6: m_a = m_a - 8'd1;
                5'd7: m_a = m_a & v;
                5'd8: m_a = m_a | v;
                5'd9: m_a = m_a ^ v;
                5'd10: m_a = ~m_a;
                5'd11: m_a = {m_a[6:0], m_a[7]};
                5'd12: begin c1 = m_a[7]; m_a = {m_a[6:0], m_cy}; m_cy = c1; end
                5'd13: m_a = {m_a[0], m_a[7:1]};
                5'd14: begin c1 = m_a[0]; m_a = {m_cy, m_a[7:1]}; m_cy = c1; end
                5'd15: m_a = {m_a[3:0], m_a[7:4]};
                5'd16: begin
                    pr = m_a * m_b;
                    m_a = pr[7:0]; m_b = pr[15:8]; m_cy = 0; m_ov = (pr > 16'd255);
                end
                5'd17: begin
                    m_cy = 0;
                    if (m_b == 0) m_ov = 1;
                    else begin m_ov = 0; pr = {m_a / m_b, m_a % m_b}; m_a = pr[15:8]; m_b = pr[7:0]; end
                end
                5'd18: begin
                    s = {1'b0, m_a};
                    if (m_ac || s[3:0] > 4'd9) s = s + 9'h006;
                    c1 = s[8];
                    if (m_cy || c1 || s[7:4] > 4'd9) s = {1'b0, s[7:0]} + 9'h060;
                    m_cy = m_cy | c1 | s[8];
                    m_a = s[7:0];
                end
                default: ;
            endcase
        end
        e.a = m_a; e.b = m_b; e.cy = m_cy; e.ac = m_ac; e.ov = m_ov; e.p = ^m_a;
        e.tag = tag;
        @(negedge clk);
        op_i = op; operand_i = v; wr_en_i = we;
        exp_q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) compare(exp_q.pop_front());
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        // R1: reset state
        exp_q.push_back('{8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R1"});
        @(negedge clk);
        rst_n = 1'b1;

        apply(5'd0, 8'h3C, 1, "R3");
        apply(5'd1, 8'h05, 1, "R3");
        apply(5'd2, 8'h0F, 1, "R4");
        apply(5'd2, 8'h7F, 1, "R4");
        apply(5'd2, 8'h40, 1, "R4");
        apply(5'd3, 8'h00, 1, "R4");
        apply(5'd2, 8'h20, 0, "R2");
        apply(5'd25, 8'h11, 1, "R2");
        apply(5'd0, 8'h10, 1, "R3");
        apply(5'd4, 8'h01, 1, "R5");
        apply(5'd0, 8'h80, 1, "R3");
        apply(5'd4, 8'h01, 1, "R5");
        apply(5'd4, 8'h90, 1, "R5");
        apply(5'd0, 8'hFF, 1, "R3");
        apply(5'd5, 8'h00, 1, "R6");
        apply(5'd6, 8'h00, 1, "R6");
        apply(5'd0, 8'hA5, 1, "R3");
        apply(5'd7, 8'h0F, 1, "R7");
        apply(5'd8, 8'hC0, 1, "R7");
        apply(5'd9, 8'hFF, 1, "R7");
        apply(5'd10, 8'h00, 1, "R7");
        apply(5'd0, 8'h81, 1, "R3");
        apply(5'd11, 8'h00, 1, "R8");
        apply(5'd13, 8'h00, 1, "R8");
        apply(5'd12, 8'h00, 1, "R8");
        apply(5'd12, 8'h00, 1, "R8");
        apply(5'd14, 8'h00, 1, "R8");
        apply(5'd14, 8'h00, 1, "R8");
        apply(5'd0, 8'h7E, 1, "R3");
        apply(5'd15, 8'h00, 1, "R9");
        apply(5'd0, 8'h0C, 1, "R3");
        apply(5'd1, 8'h15, 1, "R3");
        apply(5'd16, 8'h00, 1, "R10");
        apply(5'd0, 8'hC8, 1, "R3");
        apply(5'd1, 8'h40, 1, "R3");
        apply(5'd16, 8'h00, 1, "R10");
        apply(5'd0, 8'hFA, 1, "R3");
        apply(5'd1, 8'h07, 1, "R3");
        apply(5'd17, 8'h00, 1, "R11");
        apply(5'd1, 8'h00, 1, "R3");
        apply(5'd17, 8'h00, 1, "R11");
        apply(5'd0, 8'h05, 1, "R3");
        apply(5'd1, 8'h09, 1, "R3");
        apply(5'd17, 8'h00, 1, "R11");
        apply(5'd0, 8'h99, 1, "R3");
        apply(5'd2, 8'h99, 1, "R4");
        apply(5'd18, 8'h00, 1, "R12");
        apply(5'd0, 8'h38, 1, "R3");
        apply(5'd2, 8'h45, 1, "R4");
        apply(5'd18, 8'h00, 1, "R12");
        apply(5'd0, 8'h73, 1, "R13");
        apply(5'd5, 8'h00, 1, "R13");
        for (int k = 0; k < 16; k++) begin
            apply(5'(k % 19), 8'(k * 37 + 11), 1, "R13");
        end
        apply(5'd0, 8'h00, 0, "R2");
        apply(5'd0, 8'h00, 0, "R2");
        wait (exp_q.size() == 0);
        @(posedge clk);
        #5;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule